// File: doc/BRIEF.md
# CCM Authentication Header Formatter

This block turns a CCM job description into the byte stream that feeds the CBC-MAC half of a CCM engine, ahead of the payload. After one `start` pulse it emits a 16-byte first block, built from a flags byte, the nonce and the message length. Then it emits a length prefix for the additional authenticated data (AAD), the AAD bytes taken from an input stream, and zero bytes up to the next 16-byte boundary. The cipher core and the MAC chaining sit downstream and are not part of it.

The width L of the message-length field is derived from the nonce size as 15 minus the nonce length, so a shorter nonce leaves room for a wider length field. The AAD length prefix comes in two forms. Short lengths use two bytes. Lengths of 0xFF00 and above use a six-byte form that begins with a fixed marker. A job with no AAD produces just the first block. Output bytes move under a valid/ready handshake. The AAD input is pulled with its own valid/ready pair, only while the formatter is passing AAD through.

Top module: `ccm_hdr_fmt`

## Requirements
- R1: Byte 0 of the stream is the flags byte: bit 7 is 0, bit 6 is 1 exactly when `aadLen` is nonzero, bits 5:3 hold (`tagLen` − 2)/2, and bits 2:0 hold L − 1, where L = 15 − `nonceLen`.
- R2: Bytes 1 to `nonceLen` carry the nonce in order, nonce byte j being `nonce[8j+7:8j]`. Bytes `nonceLen`+1 to 15 carry the message length big-endian: byte 15 is `msgLen[7:0]` and byte 12 is `msgLen[31:24]`. A position above the 32 bits of `msgLen` is 0, and when L < 4 only the low L bytes appear.
- R3: When `aadLen` is 1 to 0xFEFF, bytes 16 and 17 are `aadLen[15:8]` then `aadLen[7:0]`.
- R4: When `aadLen` is 0xFF00 or more, bytes 16 to 21 are 0xFF, 0xFE, then `aadLen[31:24]`, `[23:16]`, `[15:8]` and `[7:0]`.
- R5: Right after the prefix come exactly `aadLen` bytes, taken in order from `aadData` on cycles where `aadValid` and `aadReady` are both high. `aadReady` is high only while the output stage can take a byte.
- R6: The stream is zero-padded to a multiple of 16 bytes. With `aadLen` = 0 it is exactly 16 bytes long.
- R7: `outLast` is high on the final byte of the stream and on no other byte.
- R8: A `start` with `nonceLen` outside 7 to 13 raises `cfgError` for one cycle, one edge after the start edge, and no byte is emitted.
- R9: While `outValid` is high and `outReady` is low, `outValid`, `outData` and `outLast` keep their values.
- R10: The first byte is valid two edges after the edge that samples `start`. With `outReady` held high and AAD always available, one byte moves per cycle.
- R11: A `start` that arrives while a stream is in progress, including a final byte not yet taken, is ignored. The current stream is not disturbed and no second stream follows.
- R12: After reset, `outValid`, `aadReady` and `cfgError` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a new header; the configuration is sampled on the same edge |
| nonceLen | input | 4 | Nonce length in bytes (7 to 13 are valid) |
| nonce | input | 8*NONCE_BYTES | Nonce bytes, byte j at bits 8j+7:8j |
| tagLen | input | 5 | Tag length in bytes |
| msgLen | input | MSG_W | Payload length in bytes |
| aadLen | input | 32 | AAD length in bytes |
| aadData | input | 8 | AAD input byte |
| aadValid | input | 1 | AAD input byte is valid |
| aadReady | output | 1 | Formatter takes the AAD byte this cycle |
| outData | output | 8 | Header output byte |
| outValid | output | 1 | Output byte is valid |
| outReady | input | 1 | Downstream takes the output byte |
| outLast | output | 1 | Marks the final byte of the header |
| cfgError | output | 1 | One-cycle pulse when a start carries an illegal nonce length |

## Verification
The error pulse is due one edge after the edge that samples `start`. The first byte is due one edge later still, because the control step and the output register each add a stage. After that, each accepted byte is replaced on the next edge. The bench drives every input and samples every output on the falling edge. It checks the two-edge latency at exactly those falling edges. It counts collection cycles against bytes received to confirm one byte per cycle. It records a transfer only when valid and ready were both seen before the rising edge that performs it. For the two large-AAD boundary cases it checks the leading 24 bytes and then resets the block mid-stream.

// File: rtl/ccm_hdr_pkg.sv
package ccm_hdr_pkg;

  localparam int BLK_BYTES    = 16;
  localparam int NONCE_MIN    = 7;
  localparam int NONCE_MAX    = 13;
  localparam int AAD_W        = 32;
  localparam int SHORT_PFX    = 2;
  localparam int LONG_PFX     = 6;
  localparam logic [AAD_W-1:0] LONG_AAD_MIN = 32'h0000_FF00;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_B0,
    PH_PFX,
    PH_AAD,
    PH_PAD
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       capture;
    logic       load;
    phase_e     phase;
    logic [3:0] blkIdx;
    logic [2:0] subIdx;
    logic       last;
  } ctl_strobe_t;

endpackage

// File: rtl/ccm_hdr_ctrl.sv
module ccm_hdr_ctrl
  import ccm_hdr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [3:0]       nonceLen,
  input  logic [AAD_W-1:0] aadLen,
  input  logic             aadValid,
  input  logic             outValid,
  input  logic             outReady,
  output logic             aadReady,
  output logic             cfgError,
  output ctl_strobe_t      strobe
);

  localparam logic [2:0] SHORT_END = 3'(SHORT_PFX - 1);
  localparam logic [2:0] LONG_END  = 3'(LONG_PFX - 1);

  phase_e           phase;
  logic [3:0]       blkIdx;
  logic [2:0]       subIdx;
  logic [AAD_W-1:0] aadLeft;
  logic             hasAad;
  logic             longPfx;

  logic canLoad, accept, lenOk, srcAvail, step, lastNow, blkEnd, aadEnd;
  logic [2:0] pfxEnd;

  assign canLoad  = !outValid || outReady;
  assign accept   = start && (phase == PH_IDLE) && !outValid;
  assign lenOk    = (nonceLen >= 4'(NONCE_MIN)) && (nonceLen <= 4'(NONCE_MAX));
  assign srcAvail = (phase == PH_B0) || (phase == PH_PFX) || (phase == PH_PAD) ||
                    ((phase == PH_AAD) && aadValid);
  assign step     = canLoad && srcAvail;
  assign aadReady = (phase == PH_AAD) && canLoad;
  assign blkEnd   = (blkIdx == 4'd15);
  assign aadEnd   = (aadLeft == AAD_W'(1));
  assign pfxEnd   = longPfx ? LONG_END : SHORT_END;

  always_comb begin
    unique case (phase)
      PH_B0:   lastNow = blkEnd && !hasAad;
      PH_AAD:  lastNow = blkEnd && aadEnd;
      PH_PAD:  lastNow = blkEnd;
      default: lastNow = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      blkIdx   <= '0;
      subIdx   <= '0;
      aadLeft  <= '0;
      hasAad   <= 1'b0;
      longPfx  <= 1'b0;
      cfgError <= 1'b0;
    end else begin
      cfgError <= accept && !lenOk;
      if (accept && lenOk) begin
        phase   <= PH_B0;
        blkIdx  <= '0;
        subIdx  <= '0;
        aadLeft <= aadLen;
        hasAad  <= |aadLen;
        longPfx <= aadLen >= LONG_AAD_MIN;
      end else if (step) begin
        blkIdx <= blkIdx + 4'd1;
        unique case (phase)
          PH_B0: begin
            if (blkEnd) begin
              phase  <= hasAad ? PH_PFX : PH_IDLE;
              subIdx <= '0;
            end
          end
          PH_PFX: begin
            subIdx <= subIdx + 3'd1;
            if (subIdx == pfxEnd) phase <= PH_AAD;
          end
          PH_AAD: begin
            aadLeft <= aadLeft - AAD_W'(1);
            if (aadEnd) phase <= blkEnd ? PH_IDLE : PH_PAD;
          end
          PH_PAD: begin
            if (blkEnd) phase <= PH_IDLE;
          end
          default: phase <= PH_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    strobe.capture = accept && lenOk;
    strobe.load    = step;
    strobe.phase   = phase;
    strobe.blkIdx  = blkIdx;
    strobe.subIdx  = subIdx;
    strobe.last    = lastNow;
  end

endmodule

// File: rtl/ccm_hdr_dp.sv
module ccm_hdr_dp
  import ccm_hdr_pkg::*;
#(
  parameter int MSG_W       = 32,
  parameter int NONCE_BYTES = 13
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctl_strobe_t              strobe,
  input  logic [3:0]               nonceLen,
  input  logic [8*NONCE_BYTES-1:0] nonce,
  input  logic [4:0]               tagLen,
  input  logic [MSG_W-1:0]         msgLen,
  input  logic [AAD_W-1:0]         aadLen,
  input  logic [7:0]               aadData,
  input  logic                     outReady,
  output logic [7:0]               outData,
  output logic                     outValid,
  output logic                     outLast
);

  localparam int MSG_BYTES = MSG_W / 8;

  logic [3:0]               cfgNl;
  logic [2:0]               tagCode;
  logic [8*NONCE_BYTES-1:0] nonceR;
  logic [MSG_W-1:0]         msgR;
  logic [AAD_W-1:0]         aadR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgNl   <= '0;
      tagCode <= '0;
      nonceR  <= '0;
      msgR    <= '0;
      aadR    <= '0;
    end else if (strobe.capture) begin
      cfgNl   <= nonceLen;
      tagCode <= 3'((tagLen - 5'd2) >> 1);
      nonceR  <= nonce;
      msgR    <= msgLen;
      aadR    <= aadLen;
    end
  end

  logic [7:0] flagsByte;
  assign flagsByte = {1'b0, |aadR, tagCode, 3'(4'd14 - cfgNl)};

  // first block, one lane per byte position
  logic [7:0] b0Lane [BLK_BYTES];
  for (genvar p = 0; p < BLK_BYTES; p++) begin : gLane
    if (p == 0) begin : gFlags
      assign b0Lane[p] = flagsByte;
    end else begin : gBody
      logic [7:0] nonceB, msgB;
      if (p - 1 < NONCE_BYTES) begin : gN
        assign nonceB = nonceR[8*(p-1) +: 8];
      end else begin : gNz
        assign nonceB = 8'h00;
      end
      if (BLK_BYTES - 1 - p < MSG_BYTES) begin : gM
        assign msgB = msgR[8*(BLK_BYTES-1-p) +: 8];
      end else begin : gMz
        assign msgB = 8'h00;
      end
      assign b0Lane[p] = (4'(p) <= cfgNl) ? nonceB : msgB;
    end
  end

  logic       longPfx;
  logic [7:0] pfxByte;
  assign longPfx = aadR >= LONG_AAD_MIN;

  always_comb begin
    pfxByte = 8'h00;
    if (longPfx) begin
      unique case (strobe.subIdx)
        3'd0:    pfxByte = 8'hFF;
        3'd1:    pfxByte = 8'hFE;
        3'd2:    pfxByte = aadR[31:24];
        3'd3:    pfxByte = aadR[23:16];
        3'd4:    pfxByte = aadR[15:8];
        3'd5:    pfxByte = aadR[7:0];
        default: pfxByte = 8'h00;
      endcase
    end else begin
      pfxByte = (strobe.subIdx == 3'd0) ? aadR[15:8] : aadR[7:0];
    end
  end

  logic [7:0] nextByte;
  always_comb begin
    unique case (strobe.phase)
      PH_B0:   nextByte = b0Lane[strobe.blkIdx];
      PH_PFX:  nextByte = pfxByte;
      PH_AAD:  nextByte = aadData;
      default: nextByte = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
      outLast  <= 1'b0;
    end else if (strobe.load) begin
      outValid <= 1'b1;
      outData  <= nextByte;
      outLast  <= strobe.last;
    end else if (outReady) begin
      outValid <= 1'b0;
    end
  end

endmodule

// File: rtl/ccm_hdr_fmt.sv
module ccm_hdr_fmt
  import ccm_hdr_pkg::*;
#(
  parameter int MSG_W       = 32,
  parameter int NONCE_BYTES = NONCE_MAX
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     start,
  input  logic [3:0]               nonceLen,
  input  logic [8*NONCE_BYTES-1:0] nonce,
  input  logic [4:0]               tagLen,
  input  logic [MSG_W-1:0]         msgLen,
  input  logic [AAD_W-1:0]         aadLen,
  input  logic [7:0]               aadData,
  input  logic                     aadValid,
  output logic                     aadReady,
  output logic [7:0]               outData,
  output logic                     outValid,
  input  logic                     outReady,
  output logic                     outLast,
  output logic                     cfgError
);

  ctl_strobe_t strobe;

  ccm_hdr_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .nonceLen (nonceLen),
    .aadLen   (aadLen),
    .aadValid (aadValid),
    .outValid (outValid),
    .outReady (outReady),
    .aadReady (aadReady),
    .cfgError (cfgError),
    .strobe   (strobe)
  );

  ccm_hdr_dp #(
    .MSG_W       (MSG_W),
    .NONCE_BYTES (NONCE_BYTES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .nonceLen (nonceLen),
    .nonce    (nonce),
    .tagLen   (tagLen),
    .msgLen   (msgLen),
    .aadLen   (aadLen),
    .aadData  (aadData),
    .outReady (outReady),
    .outData  (outData),
    .outValid (outValid),
    .outLast  (outLast)
  );

endmodule

// File: rtl/ccm_hdr_fmt_chk.sv
module ccm_hdr_fmt_chk (
  input logic       clk,
  input logic       rstN,
  input logic       aadReady,
  input logic [7:0] outData,
  input logic       outValid,
  input logic       outReady,
  input logic       outLast,
  input logic       cfgError
);

  // R9: a stalled byte stays put
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outLast)));

  // R5: AAD is pulled only when the output stage has room
  assert_aad_gate_R5: assert property (@(posedge clk) disable iff (!rstN)
    aadReady |-> (!outValid || outReady));

  // R7: nothing follows the final byte
  assert_last_end_R7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outLast && outReady) |=> !outValid);

  // R8: a rejected start emits nothing
  assert_err_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    cfgError |-> !outValid);

endmodule

bind ccm_hdr_fmt ccm_hdr_fmt_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .aadReady (aadReady),
  .outData  (outData),
  .outValid (outValid),
  .outReady (outReady),
  .outLast  (outLast),
  .cfgError (cfgError)
);

// File: tb/tb_ccm_hdr_fmt.sv
module tb_ccm_hdr_fmt;

  localparam int NB = 13;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [3:0]    nonceLen = '0;
  logic [8*NB-1:0] nonce;
  logic [4:0]    tagLen = '0;
  logic [31:0]   msgLen = '0;
  logic [31:0]   aadLen = '0;
  logic [7:0]    aadData;
  logic          aadValid;
  logic          aadReady;
  logic [7:0]    outData;
  logic          outValid;
  logic          outReady = 1'b0;
  logic          outLast;
  logic          cfgError;

  always #2 clk = ~clk;

  ccm_hdr_fmt dut (
    .clk(clk), .rstN(rstN), .start(start), .nonceLen(nonceLen), .nonce(nonce),
    .tagLen(tagLen), .msgLen(msgLen), .aadLen(aadLen), .aadData(aadData),
    .aadValid(aadValid), .aadReady(aadReady), .outData(outData), .outValid(outValid),
    .outReady(outReady), .outLast(outLast), .cfgError(cfgError)
  );

  function automatic logic [7:0] aadPat(input int k);
    return 8'(k * 7 + 3);
  endfunction

  function automatic logic [7:0] nonceByte(input int j);
    return 8'(8'hA0 + j);
  endfunction

  for (genvar j = 0; j < NB; j++) begin : gNonce
    assign nonce[8*j +: 8] = nonceByte(j);
  end

  // AAD source
  int   aadCnt = 0;
  int   tick = 0;
  logic srcClr = 1'b0;
  logic gapMode = 1'b0;
  always @(posedge clk) begin
    tick <= tick + 1;
    if (srcClr) aadCnt <= 0;
    else if (aadValid && aadReady) aadCnt <= aadCnt + 1;
  end
  assign aadData  = aadPat(aadCnt);
  assign aadValid = !(gapMode && (tick % 4 == 0));

  int nChecks = 0;
  int nFails  = 0;
  bit summaryDone = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!summaryDone) begin
      summaryDone = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  // expected stream model
  logic [7:0] expBuf [0:511];
  int expLen;
  int expPfx;

  task automatic buildExp(input int nl, input int tl, input logic [31:0] msg, input int aad);
    int L;
    int pos;
    int k;
    L = 15 - nl;
    for (int i = 0; i < 512; i++) expBuf[i] = 8'h00;
    expBuf[0] = {1'b0, (aad != 0), 3'((tl - 2) / 2), 3'(L - 1)};
    for (int i = 1; i <= 15 - L; i++) expBuf[i] = nonceByte(i - 1);
    for (int i = 16 - L; i <= 15; i++) begin
      k = 15 - i;
      expBuf[i] = (k < 4) ? msg[8*k +: 8] : 8'h00;
    end
    pos = 16;
    expPfx = 0;
    if (aad != 0) begin
      if (aad < 'hFF00) begin
        expBuf[16] = 8'(aad >> 8); expBuf[17] = 8'(aad);
        expPfx = 2;
      end else begin
        expBuf[16] = 8'hFF; expBuf[17] = 8'hFE;
        expBuf[18] = 8'(aad >> 24); expBuf[19] = 8'(aad >> 16);
        expBuf[20] = 8'(aad >> 8);  expBuf[21] = 8'(aad);
        expPfx = 6;
      end
      pos = 16 + expPfx;
      for (int a = 0; a < aad; a++) begin
        if (pos < 512) expBuf[pos] = aadPat(a);
        pos++;
      end
    end
    expLen = ((pos + 15) / 16) * 16;
  endtask

  // collector
  logic [7:0] gotBuf [0:511];
  int gotLen, lastCount, lastIdx, collCyc;
  bit holdBad;

  task automatic collect(input int want, input int rmode, input bit busyPoke);
    int  cyc;
    bit  prevStall;
    bit  done;
    logic [7:0] prevData;
    logic prevLast;
    cyc = 0; prevStall = 0; done = 0; prevData = '0; prevLast = 0;
    gotLen = 0; lastCount = 0; lastIdx = -1; holdBad = 0;
    while (!done && cyc < 4000) begin
      case (rmode)
        1:       outReady = (cyc % 2 == 0);
        2:       outReady = (cyc % 3 == 0);
        default: outReady = 1'b1;
      endcase
      if (prevStall && !(outValid && outData == prevData && outLast == prevLast)) holdBad = 1;
      if (outValid && outReady) begin
        if (gotLen < 512) gotBuf[gotLen] = outData;
        if (outLast) begin
          lastCount++;
          if (lastIdx < 0) lastIdx = gotLen;
        end
        gotLen++;
        if (outLast || gotLen >= want) done = 1;
      end
      prevStall = outValid && !outReady;
      prevData  = outData;
      prevLast  = outLast;
      if (busyPoke && cyc == 5) begin
        start = 1'b1; nonceLen = 4'd9; aadLen = 32'd3; msgLen = 32'h55;
      end else begin
        start = 1'b0;
      end
      collCyc = cyc;
      if (!done) begin
        @(negedge clk);
        cyc++;
      end
    end
    start = 1'b0;
  endtask

  task automatic launch(input int nl, input int tl, input logic [31:0] msg,
                        input logic [31:0] aad, input bit gap);
    srcClr = 1'b1; gapMode = gap;
    @(negedge clk);
    srcClr = 1'b0;
    nonceLen = 4'(nl); tagLen = 5'(tl); msgLen = msg; aadLen = aad;
    outReady = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  typedef struct packed {
    logic [3:0]  nl;
    logic [4:0]  tl;
    logic [31:0] msg;
    logic [15:0] aad;
    logic        gap;
    logic [1:0]  rmode;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{4'd13, 5'd16, 32'h0000_1234, 16'd0,  1'b0, 2'd0},
    '{4'd7,  5'd4,  32'hDEAD_BEEF, 16'd5,  1'b0, 2'd0},
    '{4'd12, 5'd8,  32'h00AB_CDEF, 16'd14, 1'b0, 2'd0},
    '{4'd11, 5'd16, 32'h0102_0304, 16'd30, 1'b1, 2'd1},
    '{4'd8,  5'd6,  32'h0000_0005, 16'd1,  1'b0, 2'd2},
    '{4'd10, 5'd12, 32'h8000_0000, 16'd0,  1'b0, 2'd1},
    '{4'd13, 5'd14, 32'h0001_2345, 16'd40, 1'b1, 2'd2}
  };

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; start = 1'b0; outReady = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    vec_t c;
    int   bad;
    string tag;
    bit   quiet;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R12 reset state
    check(!outValid, "R12", "outValid after reset", 32'(outValid), 0);
    check(!aadReady, "R12", "aadReady after reset", 32'(aadReady), 0);
    check(!cfgError, "R12", "cfgError after reset", 32'(cfgError), 0);

    for (int v = 0; v < NVEC; v++) begin
      c = VECS[v];
      buildExp(int'(c.nl), int'(c.tl), c.msg, int'(c.aad));
      launch(int'(c.nl), int'(c.tl), c.msg, {16'd0, c.aad}, c.gap);
      // R10: one edge after start, nothing yet
      check(!outValid, "R10", "valid one edge after start", 32'(outValid), 0);
      @(negedge clk);
      check(outValid && outData == expBuf[0], "R10", "first byte two edges after start",
            {23'd0, outValid, outData}, {24'd1, expBuf[0]});
      collect(512, int'(c.rmode), 1'b1);
      check(gotLen == expLen, "R6", "stream length", 32'(gotLen), 32'(expLen));
      bad = -1;
      for (int i = 0; i < gotLen && i < expLen && i < 512; i++)
        if (bad < 0 && gotBuf[i] != expBuf[i]) bad = i;
      if (bad == 0) tag = "R1";
      else if (bad > 0 && bad < 16) tag = "R2";
      else if (bad >= 16 && bad < 16 + expPfx) tag = "R3";
      else if (bad >= 16 && bad < 16 + expPfx + int'(c.aad)) tag = "R5";
      else tag = "R6";
      check(bad < 0, tag, "stream byte content", (bad < 0) ? 0 : 32'(gotBuf[bad]),
            (bad < 0) ? 0 : 32'(expBuf[bad]));
      check(lastCount == 1 && lastIdx == gotLen - 1, "R7", "last flag position",
            32'(lastIdx), 32'(gotLen - 1));
      check(!holdBad, "R9", "stalled byte held", 32'(holdBad), 0);
      if (c.rmode == 2'd0 && !c.gap)
        check(collCyc == gotLen - 1, "R10", "one byte per cycle", 32'(collCyc), 32'(gotLen - 1));
      // R11: start during the stream did not spawn a second stream
      quiet = 1;
      outReady = 1'b1;
      repeat (5) begin
        @(negedge clk);
        if (outValid) quiet = 0;
      end
      check(quiet, "R11", "no stream after busy start", 32'(!quiet), 0);
      outReady = 1'b0;
    end

    // R4: long prefix at the lower boundary
    buildExp(13, 16, 32'h1, 'hFF00);
    launch(13, 16, 32'h1, 32'h0000_FF00, 1'b0);
    @(negedge clk);
    collect(24, 0, 1'b0);
    check(gotBuf[0] == 8'h79, "R1", "flags with AAD", 32'(gotBuf[0]), 32'h79);
    bad = -1;
    for (int i = 16; i < 22; i++) if (bad < 0 && gotBuf[i] != expBuf[i]) bad = i;
    check(bad < 0, "R4", "long prefix bytes", (bad < 0) ? 0 : 32'(gotBuf[bad]),
          (bad < 0) ? 0 : 32'(expBuf[bad]));
    check(gotBuf[22] == aadPat(0) && gotBuf[23] == aadPat(1), "R5", "AAD after long prefix",
          {16'd0, gotBuf[22], gotBuf[23]}, {16'd0, aadPat(0), aadPat(1)});
    doReset();
    check(!outValid && !aadReady, "R12", "idle after mid-stream reset",
          {30'd0, outValid, aadReady}, 0);

    // R3: short prefix at the upper boundary
    buildExp(12, 10, 32'h77, 'hFEFF);
    launch(12, 10, 32'h77, 32'h0000_FEFF, 1'b0);
    @(negedge clk);
    collect(24, 0, 1'b0);
    check(gotBuf[16] == 8'hFE && gotBuf[17] == 8'hFF, "R3", "short prefix at 0xFEFF",
          {16'd0, gotBuf[16], gotBuf[17]}, 32'hFEFF);
    check(gotBuf[18] == aadPat(0), "R5", "AAD after short prefix", 32'(gotBuf[18]), 32'(aadPat(0)));
    doReset();

    // R8: illegal nonce lengths
    for (int e = 0; e < 2; e++) begin
      launch((e == 0) ? 6 : 14, 16, 32'h10, 32'd4, 1'b0);
      check(cfgError && !outValid, "R8", "error pulse", {30'd0, cfgError, outValid}, 32'h2);
      @(negedge clk);
      check(!cfgError, "R8", "error lasts one cycle", 32'(cfgError), 0);
      quiet = 1;
      outReady = 1'b1;
      repeat (20) begin
        @(negedge clk);
        if (outValid) quiet = 0;
      end
      check(quiet, "R8", "no bytes after illegal nonce", 32'(!quiet), 0);
      outReady = 1'b0;
    end

    finishRun();
  end

endmodule